// File: doc/BRIEF.md
# Clock Register Map With Read-Coherent Snapshot

This block sits between a byte-wide host port and the running timekeeping counters of a real-time clock. It presents eight byte locations: locations 0 to 6 show the current time fields and location 7 is a control byte. The host uses read and write strobes with an address. A sequential flag makes the block use its own address pointer instead of the supplied address. The pointer always moves to the location after the one last accessed, and it wraps from 7 to 0.

The host never reads the live counters directly. It reads a visible copy that reloads from the counters every cycle. A read of any time location opens a hold session. During the session the visible copy stops reloading, so a multi-byte read sees one coherent instant. The counters themselves keep running. The session closes when the host signals end of transfer, or after `HOLD_CYCLES` clock cycles at most, which is the 250 ms bound at the system tick rate. On the next cycle the visible copy picks up the current time again.

Writes to locations 0 to 6 go straight out to the counter load port and also update the visible byte at once. Bit 7 of the control byte drives the pull-down enable of an open-drain output pin. The pin is pulled low while that bit is 0.

Top module: `clkmap_regif`

## Requirements
- R1: After synchronous reset, `rd_valid` and `rd_data` are 0, the control byte reads 0x80 and `out_pull_en` is 0.
- R2: A read strobe returns its byte on `rd_data` with `rd_valid` high on the cycle after the strobe. Locations 0 to 6 give visible byte n, which is `live_time[8n+7:8n]`, and location 7 gives the control byte.
- R3: While no hold session is open, the visible copy follows `live_time` with one cycle of delay.
- R4: A read of location 0 to 6 opens a hold session. Until the session closes, reads return the time as it was at that first read, even if `live_time` changes.
- R5: A cycle with `host_end` high closes an open session, and reads after that return the current `live_time`.
- R6: A session closes by itself `HOLD_CYCLES` cycles after it opened. A further read in that window does not restart the timer.
- R7: A read of location 7 does not open a hold session.
- R8: With `host_seq` high, the access uses the internal pointer and ignores `host_addr`. After every read or write the pointer becomes the accessed location plus one, and location 7 is followed by 0.
- R9: A write to location 0 to 6 raises `load_en` in the same cycle, with `load_addr` and `load_data` equal to the location and the byte. Later reads of that location return the written byte, including reads inside a hold session.
- R10: A write to location 7 stores the control byte, which reads back unchanged. From the next cycle on, `out_pull_en` equals the inverse of its bit 7.
- R11: A write to location 7 never raises `load_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Read strobe, one cycle per byte |
| host_wr | input | 1 | Write strobe; takes priority over a read in the same cycle |
| host_seq | input | 1 | Use the internal pointer instead of `host_addr` |
| host_end | input | 1 | End of transfer; closes a hold session |
| host_addr | input | 3 | Location for non-sequential accesses |
| host_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, registered |
| rd_valid | output | 1 | High on the cycle after a read strobe |
| live_time | input | 56 | Live counter bytes; byte n at bits 8n+7:8n |
| load_en | output | 1 | Counter load strobe |
| load_addr | output | 3 | Counter field to load |
| load_data | output | 8 | Byte to load |
| out_pull_en | output | 1 | Pull-down enable for the open-drain output |

## Verification
The hardest case to reach is the automatic end of a hold session. The bench has to keep a session open across many cycles while the live counters change underneath it. It also has to show that the visible copy stays frozen until the end of the window and no longer. The bench shortens `HOLD_CYCLES` to 40 and opens a session with a single read. It then changes a counter byte and reads again well inside the window, expecting the old value. Last, it waits until safely past the window and reads once more, expecting the new value. Running the same pattern with an explicit end of transfer and with a control-byte read separates the three ways a session can open or close.

// File: rtl/clkmap_pkg.sv
package clkmap_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int NUM_REGS = 8;
    localparam int CLK_REGS = 7;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t CTRL_ADDR = addr_t'(NUM_REGS - 1);

    // One decoded host access, valid for a single cycle.
    typedef struct packed {
        logic  rd_clk;
        logic  rd_ctl;
        logic  wr_clk;
        logic  wr_ctl;
        addr_t addr;
        byte_t data;
    } access_t;

    function automatic logic is_clock_addr(addr_t a);
        return int'(a) < CLK_REGS;
    endfunction

    function automatic addr_t next_addr(addr_t a);
        if (int'(a) == NUM_REGS - 1)
            return '0;
        return a + addr_t'(1);
    endfunction

endpackage

// File: rtl/clkmap_access.sv
module clkmap_access
    import clkmap_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    host_rd,
    input  logic    host_wr,
    input  logic    host_seq,
    input  addr_t   host_addr,
    input  byte_t   host_wdata,
    output access_t acc
);

    addr_t ptr_q;
    addr_t eff_addr;
    logic  any_access;

    assign eff_addr   = host_seq ? ptr_q : host_addr;
    assign any_access = host_rd | host_wr;

    always_comb begin
        acc        = '0;
        acc.addr   = eff_addr;
        acc.data   = host_wdata;
        acc.wr_clk = host_wr & is_clock_addr(eff_addr);
        acc.wr_ctl = host_wr & ~is_clock_addr(eff_addr);
        acc.rd_clk = host_rd & ~host_wr & is_clock_addr(eff_addr);
        acc.rd_ctl = host_rd & ~host_wr & ~is_clock_addr(eff_addr);
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (any_access)
            ptr_q <= next_addr(eff_addr);
    end

    // R8: pointer lands one past the accessed location
    assert_ptr_advance_R8: assert property (@(posedge clk) disable iff (rst)
        any_access |=> ptr_q == next_addr($past(eff_addr)));

    // R8: sequential access ignores the supplied address
    assert_seq_uses_ptr_R8: assert property (@(posedge clk) disable iff (rst)
        (host_seq && any_access) |-> acc.addr == ptr_q);

endmodule

// File: rtl/clkmap_hold_timer.sv
module clkmap_hold_timer #(
    parameter int HOLD_CYCLES = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic stop,
    output logic active
);

    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             expire;

    assign expire = active && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt_q  <= '0;
        end else if (stop || expire) begin
            active <= 1'b0;
            cnt_q  <= '0;
        end else if (active) begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end else if (start) begin
            active <= 1'b1;
            cnt_q  <= '0;
        end
    end

    // R6: the window never exceeds its bound
    assert_window_bound_R6: assert property (@(posedge clk) disable iff (rst)
        active |-> cnt_q <= LAST);

    // R5: end of transfer closes the session
    assert_end_closes_R5: assert property (@(posedge clk) disable iff (rst)
        (active && stop) |=> !active);

    // R4: a clock read opens a session
    assert_read_opens_R4: assert property (@(posedge clk) disable iff (rst)
        (start && !active && !stop) |=> active);

endmodule

// File: rtl/clkmap_shadow.sv
module clkmap_shadow
    import clkmap_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       freeze,
    input  access_t                    acc,
    input  logic [CLK_REGS*DATA_W-1:0] live_time,
    output byte_t [CLK_REGS-1:0]       vis
);

    for (genvar i = 0; i < CLK_REGS; i++) begin : g_byte
        logic hit;
        assign hit = acc.wr_clk && (acc.addr == addr_t'(i));

        always_ff @(posedge clk) begin
            if (rst)
                vis[i] <= '0;
            else if (hit)
                vis[i] <= acc.data;
            else if (!freeze)
                vis[i] <= live_time[i*DATA_W +: DATA_W];
        end
    end

    // R4: nothing but a host write moves the copy during a hold
    assert_frozen_copy_R4: assert property (@(posedge clk) disable iff (rst)
        (freeze && !acc.wr_clk) |=> $stable(vis));

    // R3: when idle the copy tracks the counters
    assert_tracks_live_R3: assert property (@(posedge clk) disable iff (rst)
        (!freeze && !acc.wr_clk) |=> vis == $past(live_time));

endmodule

// File: rtl/clkmap_ctrl_read.sv
module clkmap_ctrl_read
    import clkmap_pkg::*;
#(
    parameter byte_t CTRL_RESET = 8'h80
) (
    input  logic                 clk,
    input  logic                 rst,
    input  access_t              acc,
    input  byte_t [CLK_REGS-1:0] vis,
    output byte_t                rd_data,
    output logic                 rd_valid,
    output logic                 out_pull_en
);

    byte_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= CTRL_RESET;
        else if (acc.wr_ctl)
            ctrl_q <= acc.data;
    end

    assign out_pull_en = ~ctrl_q[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= acc.rd_clk | acc.rd_ctl;
            if (acc.rd_ctl)
                rd_data <= ctrl_q;
            else if (acc.rd_clk)
                rd_data <= vis[acc.addr];
        end
    end

    // R10: the pin follows the last control write
    assert_pin_follows_R10: assert property (@(posedge clk) disable iff (rst)
        acc.wr_ctl |=> out_pull_en == !$past(acc.data[DATA_W-1]));

    // R2: read data is valid exactly one cycle after a strobe
    assert_valid_timing_R2: assert property (@(posedge clk) disable iff (rst)
        (acc.rd_clk || acc.rd_ctl) |=> rd_valid);

endmodule

// File: rtl/clkmap_regif.sv
module clkmap_regif
    import clkmap_pkg::*;
#(
    parameter int    HOLD_CYCLES = 32768,
    parameter byte_t CTRL_RESET  = 8'h80
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_rd,
    input  logic        host_wr,
    input  logic        host_seq,
    input  logic        host_end,
    input  logic [2:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  rd_data,
    output logic        rd_valid,
    input  logic [55:0] live_time,
    output logic        load_en,
    output logic [2:0]  load_addr,
    output logic [7:0]  load_data,
    output logic        out_pull_en
);

    access_t              acc;
    logic                 hold_active;
    logic                 freeze;
    byte_t [CLK_REGS-1:0] vis;

    clkmap_access u_access (
        .clk        (clk),
        .rst        (rst),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_seq   (host_seq),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .acc        (acc)
    );

    clkmap_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .start  (acc.rd_clk),
        .stop   (host_end),
        .active (hold_active)
    );

    // The strobe cycle itself is frozen so the first byte matches the rest.
    assign freeze = hold_active | acc.rd_clk;

    clkmap_shadow u_shadow (
        .clk       (clk),
        .rst       (rst),
        .freeze    (freeze),
        .acc       (acc),
        .live_time (live_time),
        .vis       (vis)
    );

    clkmap_ctrl_read #(.CTRL_RESET(CTRL_RESET)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .acc         (acc),
        .vis         (vis),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid),
        .out_pull_en (out_pull_en)
    );

    assign load_en   = acc.wr_clk;
    assign load_addr = acc.addr;
    assign load_data = acc.data;

    // R11: a control write never reaches the counters
    assert_ctrl_no_load_R11: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_seq && host_addr == CTRL_ADDR) |-> !load_en);

    // R9: a time write reaches the load port with its byte
    assert_load_pass_R9: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_seq && host_addr != CTRL_ADDR) |->
            (load_en && load_data == host_wdata && load_addr == host_addr));

endmodule

// File: tb/clkmap_regif_test.sv
module clkmap_regif_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_rd, host_wr, host_seq, host_end;
    logic [2:0]  host_addr;
    logic [7:0]  host_wdata;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [55:0] live_time;
    logic        load_en;
    logic [2:0]  load_addr;
    logic [7:0]  load_data;
    logic        out_pull_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model of the counters: loaded by the block or poked by tests.
    logic [7:0] live_b [7];
    logic       poke_en = 1'b0;
    logic [2:0] poke_a  = '0;
    logic [7:0] poke_d  = '0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (load_en && load_addr < 3'd7)
            live_b[load_addr] <= load_data;
        else if (poke_en)
            live_b[poke_a] <= poke_d;
    end

    always_comb
        for (int i = 0; i < 7; i++)
            live_time[i*8 +: 8] = live_b[i];

    clkmap_regif #(.HOLD_CYCLES(40), .CTRL_RESET(8'h80)) uut (
        .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr),
        .host_seq(host_seq), .host_end(host_end), .host_addr(host_addr),
        .host_wdata(host_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
        .live_time(live_time), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .out_pull_en(out_pull_en)
    );

    typedef struct packed {
        logic [2:0] a;
        logic [7:0] d;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 8'h59}, '{3'd1, 8'h12}, '{3'd2, 8'h23},
        '{3'd3, 8'h05}, '{3'd4, 8'h31}, '{3'd5, 8'h12},
        '{3'd6, 8'h99}, '{3'd7, 8'h00}, '{3'd7, 8'h85}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [2:0] a, input logic s, input string req,
                           input logic [7:0] exp);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a; host_seq = s;
        @(negedge clk);
        host_rd = 1'b0; host_seq = 1'b0;
        chk(req, {7'd0, rd_valid}, 8'd1);
        chk(req, rd_data, exp);
    endtask

    task automatic do_end();
        @(negedge clk); host_end = 1'b1;
        @(negedge clk); host_end = 1'b0;
    endtask

    task automatic poke(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); poke_en = 1'b1; poke_a = a; poke_d = d;
        @(negedge clk); poke_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; host_rd = 0; host_wr = 0; host_seq = 0; host_end = 0;
        host_addr = '0; host_wdata = '0;
        for (int i = 0; i < 7; i++) live_b[i] = 8'h10 + 8'(i);
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1 rd_valid", {7'd0, rd_valid}, 8'd0);
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 out_pull_en", {7'd0, out_pull_en}, 8'd0);
        rst = 1'b0;
        do_read(3'd7, 1'b0, "R1 ctrl reset", 8'h80);

        // R2 R3: single reads of every time byte after idle tracking
        repeat (2) @(negedge clk);
        for (int i = 0; i < 7; i++)
            do_read(3'(i), 1'b0, "R2 R3 single read", 8'h10 + 8'(i));
        do_end();

        // R9 R10 R11: write/readback table
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            host_wr = 1'b1; host_addr = VECS[v].a; host_wdata = VECS[v].d;
            #1;
            if (VECS[v].a != 3'd7) begin
                chk("R9 load_en", {7'd0, load_en}, 8'd1);
                chk("R9 load_addr", {5'd0, load_addr}, {5'd0, VECS[v].a});
                chk("R9 load_data", load_data, VECS[v].d);
            end else begin
                chk("R11 no load", {7'd0, load_en}, 8'd0);
            end
            @(negedge clk);
            host_wr = 1'b0;
            if (VECS[v].a == 3'd7)
                chk("R10 pin", {7'd0, out_pull_en}, {7'd0, ~VECS[v].d[7]});
            do_read(VECS[v].a, 1'b0, "R9 R10 readback", VECS[v].d);
            do_end();
        end

        // R4 R5: freeze during session, release on end of transfer
        repeat (2) @(negedge clk);
        do_read(3'd0, 1'b0, "R4 open", 8'h59);
        poke(3'd0, 8'h42);
        repeat (3) @(negedge clk);
        do_read(3'd0, 1'b0, "R4 held", 8'h59);
        do_end();
        repeat (2) @(negedge clk);
        do_read(3'd0, 1'b0, "R5 released", 8'h42);
        do_end();

        // R7: a control read opens no session
        do_read(3'd7, 1'b0, "R7 ctrl read", 8'h85);
        poke(3'd1, 8'h34);
        repeat (3) @(negedge clk);
        do_read(3'd1, 1'b0, "R7 not frozen", 8'h34);
        do_end();

        // R6: session times out without end of transfer
        repeat (2) @(negedge clk);
        do_read(3'd2, 1'b0, "R6 open", 8'h23);
        poke(3'd2, 8'h57);
        repeat (25) @(negedge clk);
        do_read(3'd2, 1'b0, "R6 inside window", 8'h23);
        repeat (20) @(negedge clk);
        do_read(3'd2, 1'b0, "R6 after window", 8'h57);
        do_end();

        // R8: sequential burst from 3 wraps through 7 to 0
        repeat (2) @(negedge clk);
        do_read(3'd3, 1'b0, "R8 start", 8'h05);
        do_read(3'd0, 1'b1, "R8 seq 4", 8'h31);
        do_read(3'd0, 1'b1, "R8 seq 5", 8'h12);
        do_read(3'd0, 1'b1, "R8 seq 6", 8'h99);
        do_read(3'd0, 1'b1, "R8 seq 7", 8'h85);
        do_read(3'd6, 1'b1, "R8 wrap 0", 8'h42);
        do_end();

        // R9: write inside an open session is visible at once
        do_read(3'd4, 1'b0, "R9 open", 8'h31);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 3'd4; host_wdata = 8'h77;
        @(negedge clk);
        host_wr = 1'b0;
        do_read(3'd4, 1'b0, "R9 write in session", 8'h77);
        do_end();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule